// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral core and tells the surrounding data path what it may do. There are three states: reset, run and pause. Software selects a state by writing a two-bit code into the state register. The register's read value includes a ready flag. That flag goes low while a newly accepted state is still settling, and software waits for it to return high before it writes the next request. Leaving pause for reset is guarded. Software must write the clear code twice in a row, and a single clear write changes nothing.

A separate software-reset register forces the reset state at once and wipes the mode and operational registers. Each time the block lands in reset it gives a one-cycle flush pulse, which empties the FIFOs and zeroes the byte counters. The transfer enable is high only in run. In pause the counters and the FIFO contents are held, so the transmit FIFO can be loaded before the transfer starts. Access is through a plain write strobe and a read strobe with a two-bit word address.

Top module: `run_state_ctrl`

## Requirements
- R1: After reset the state field is 0 (reset), the ready flag is high, the mode and operational registers read 0, and flush_o and xfer_en_o are low.
- R2: A state-register write (address 0) of code 0 (reset), 1 (run) or 3 (pause) sets the state field to that code from any state, provided the ready flag is high. This holds for a write of the state already held.
- R3: The state register reads {ready, state} in bits 2:0, with the ready flag at bit 2 and zeros above. After an accepted state write, ready reads low for exactly SETTLE_CYC cycles and then returns high.
- R4: A state-register write made while ready is low is ignored and leaves the state unchanged.
- R5: A write of code 2 (clear) in the reset or run state is ignored. The state stays the same and ready stays high.
- R6: In pause, one accepted write of code 2 leaves the state in pause, and ready drops. A second accepted write of code 2, made directly after it, moves the state to reset.
- R7: Any other accepted state write between the two clear writes cancels the pending clear. A later single clear write then leaves the state in pause.
- R8: A write to address 1 with bit 0 set forces reset in the next cycle, even while ready is low. It clears the mode and operational registers and drops ready. A write to address 1 with bit 0 clear has no effect.
- R9: flush_o is high for exactly one cycle after any accepted state write or software reset whose result is the reset state. It is never high in any other state.
- R10: xfer_en_o is high exactly while the state is run.
- R11: The mode register (address 2, MODE_W bits) and the operational register (address 3, OP_W bits) read back what was written. rdata_o is 0 while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address: 0 state, 1 software reset, 2 mode, 3 operational |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational while rd_i is high |
| state_o | output | 2 | Current state code |
| valid_o | output | 1 | Ready flag: high when the state has settled |
| xfer_en_o | output | 1 | Data movement enable, high in run |
| flush_o | output | 1 | One-cycle pulse that clears counters and FIFOs on entry to reset |
| mode_o | output | MODE_W | Mode register contents |
| op_o | output | OP_W | Operational register contents |

## Verification
The properties assume that a write strobe lasts exactly one clock cycle and that the address and data are stable while it is high. Under that assumption, each strobe counts as one request, which is what the two-write pause exit depends on. The bench drives every strobe for a single cycle from the falling edge. It sweeps each reachable start state against every request code. It waits out the settle window unless a test is meant to probe a write made during settling. The settle-window test and the software-reset-while-busy test deliberately write during that window.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;

  localparam logic [1:0] ADDR_STATE = 2'd0;
  localparam logic [1:0] ADDR_SWRST = 2'd1;
  localparam logic [1:0] ADDR_MODE  = 2'd2;
  localparam logic [1:0] ADDR_OP    = 2'd3;
endpackage

// File: rtl/rsc_settle.sv
module rsc_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic valid_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign valid_o = (cnt_q == '0);
endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
  import rsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] code_i,
  input  logic       swrst_i,
  output run_state_e state_o,
  output logic       accept_o,
  output logic       flush_o
);
  run_state_e state_q, nxt;
  logic       arm_q, flush_q;

  // clear code only counts in pause
  assign accept_o = req_i && (code_i != ST_CLEAR || state_q == ST_PAUSE);

  always_comb begin
    if (code_i == ST_CLEAR) nxt = arm_q ? ST_RESET : state_q;
    else                    nxt = run_state_e'(code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      arm_q   <= 1'b0;
      flush_q <= 1'b0;
    end else if (swrst_i) begin
      state_q <= ST_RESET;
      arm_q   <= 1'b0;
      flush_q <= 1'b1;
    end else if (accept_o) begin
      state_q <= nxt;
      arm_q   <= (state_q == ST_PAUSE) && (code_i == ST_CLEAR) && !arm_q;
      flush_q <= (nxt == ST_RESET);
    end else begin
      flush_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 4,
  parameter int OP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              swrst_i,
  input  logic [1:0]        state_i,
  input  logic              valid_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [MODE_W-1:0] mode_q;
  logic [OP_W-1:0]   op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      op_q   <= '0;
    end else if (swrst_i) begin
      mode_q <= '0;
      op_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_MODE) mode_q <= wdata_i[MODE_W-1:0];
      if (addr_i == ADDR_OP)   op_q   <= wdata_i[OP_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADDR_STATE: rdata_o[2:0]        = {valid_i, state_i};
        ADDR_MODE:  rdata_o[MODE_W-1:0] = mode_q;
        ADDR_OP:    rdata_o[OP_W-1:0]   = op_q;
        default:    rdata_o             = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign op_o   = op_q;
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MODE_W     = 4,
  parameter int OP_W       = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        state_o,
  output logic              valid_o,
  output logic              xfer_en_o,
  output logic              flush_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [OP_W-1:0]   op_o
);
  initial begin
    if (DATA_W < 3 || DATA_W < MODE_W || DATA_W < OP_W || SETTLE_CYC < 1)
      $error("run_state_ctrl: bad parameters");
  end

  logic       swrst, state_req, accept, valid;
  run_state_e state;

  assign swrst     = wr_i && (addr_i == ADDR_SWRST) && wdata_i[0];
  assign state_req = wr_i && (addr_i == ADDR_STATE) && valid;

  rsc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (state_req),
    .code_i   (wdata_i[1:0]),
    .swrst_i  (swrst),
    .state_o  (state),
    .accept_o (accept),
    .flush_o  (flush_o)
  );

  rsc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept || swrst),
    .valid_o (valid)
  );

  rsc_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W), .OP_W(OP_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .swrst_i (swrst),
    .state_i (state),
    .valid_i (valid),
    .mode_o  (mode_o),
    .op_o    (op_o),
    .rdata_o (rdata_o)
  );

  assign state_o   = state;
  assign valid_o   = valid;
  assign xfer_en_o = (state == ST_RUN);
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk
  import rsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 4,
  parameter int OP_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [1:0]        state_o,
  input logic              valid_o,
  input logic              flush_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [OP_W-1:0]   op_o
);
  logic swrst, st_wr;
  assign swrst = wr_i && (addr_i == ADDR_SWRST) && wdata_i[0];
  assign st_wr = wr_i && (addr_i == ADDR_STATE);

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !swrst) |=> $stable(state_o));

  // R3
  settle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && st_wr && (wdata_i[1:0] != 2'd2 || state_o == 2'd3)) |=> !valid_o);

  // R5
  clear_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wdata_i[1:0] == 2'd2 && state_o != 2'd3) |=> $stable(state_o));

  // R6
  pause_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !swrst && !(st_wr && (wdata_i[1:0] == 2'd0 || wdata_i[1:0] == 2'd2)))
      |=> state_o != 2'd0);

  // R8
  swrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (state_o == 2'd0 && mode_o == '0 && op_o == '0 && !valid_o));

  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> state_o == 2'd0);
endmodule

bind run_state_ctrl rsc_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W), .OP_W(OP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .state_o (state_o),
  .valid_o (valid_o),
  .flush_o (flush_o),
  .mode_o  (mode_o),
  .op_o    (op_o)
);

// File: tb/sim_run_state_ctrl.sv
`timescale 1ns/1ps
module sim_run_state_ctrl;
  localparam int DATA_W = 16;
  localparam int MODE_W = 4;
  localparam int OP_W   = 8;
  localparam int SETTLE = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic [1:0]        state_o;
  logic              valid_o, xfer_en_o, flush_o;
  logic [MODE_W-1:0] mode_o;
  logic [OP_W-1:0]   op_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  run_state_ctrl #(.DATA_W(DATA_W), .MODE_W(MODE_W), .OP_W(OP_W), .SETTLE_CYC(SETTLE)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .state_o(state_o), .valid_o(valid_o),
    .xfer_en_o(xfer_en_o), .flush_o(flush_o), .mode_o(mode_o), .op_o(op_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle strobe; returns at the falling edge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    rd_i = 1'b1; addr_i = a;
    #2;
    d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk_i);
  endtask

  task automatic go_to(input logic [1:0] s);
    wr(2'd1, 16'd1);
    settle();
    if (s != 2'd0) begin
      wr(2'd0, {14'd0, s});
      settle();
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 valid", valid_o, 1);
    chk("R1 mode", mode_o, 0);
    chk("R1 op", op_o, 0);
    chk("R1 flush", flush_o, 0);
    chk("R1 xfer", xfer_en_o, 0);
    // R11 idle read returns zero
    chk("R11 idle rdata", rdata_o, 0);

    // R2 R5 R9 R10 sweep: start state x code
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      for (int c = 0; c < 4; c++) begin
        logic [1:0] exp_s;
        bit acc;
        go_to(s[1:0]);
        acc   = (c != 2) || (s == 3);
        exp_s = (c == 2) ? s[1:0] : c[1:0];
        wr(2'd0, c[15:0]);
        chk((c == 2) ? "R5 state" : "R2 state", state_o, exp_s);
        chk((c == 2) ? "R5 valid" : "R3 valid drop", valid_o, !acc);
        chk("R9 flush", flush_o, acc && exp_s == 2'd0);
        chk("R10 xfer", xfer_en_o, exp_s == 2'd1);
        @(negedge clk_i);
        chk("R9 flush one cycle", flush_o, 0);
        settle();
      end
    end

    // R3 settle length and read layout
    go_to(2'd0);
    wr(2'd0, 16'd1);
    repeat (SETTLE - 1) @(negedge clk_i);
    chk("R3 still low", valid_o, 0);
    rd(2'd0, d);
    chk("R3 read busy", d, 16'h0001);
    @(negedge clk_i);
    chk("R3 high", valid_o, 1);
    rd(2'd0, d);
    chk("R3 read ready", d, 16'h0005);

    // R4 write while busy ignored
    wr(2'd0, 16'd3);
    wr(2'd0, 16'd0);
    settle();
    chk("R4 state", state_o, 3);

    // R6 double clear
    go_to(2'd3);
    wr(2'd0, 16'd2);
    settle();
    chk("R6 first clear", state_o, 3);
    wr(2'd0, 16'd2);
    chk("R6 second clear", state_o, 0);
    chk("R9 flush on clear", flush_o, 1);
    settle();

    // R7 intervening write cancels arming
    go_to(2'd3);
    wr(2'd0, 16'd2); settle();
    wr(2'd0, 16'd3); settle();
    wr(2'd0, 16'd2); settle();
    chk("R7 cancel", state_o, 3);
    wr(2'd0, 16'd2); settle();
    chk("R7 rearm", state_o, 0);

    // R11 mode / op read back
    wr(2'd2, 16'h00A5);
    wr(2'd3, 16'h00C3);
    rd(2'd2, d); chk("R11 mode", d, 16'h0005);
    rd(2'd3, d); chk("R11 op", d, 16'h00C3);

    // R8 bit0 clear: no effect
    wr(2'd0, 16'd1); settle();
    wr(2'd1, 16'hFFFE);
    chk("R8 no-op state", state_o, 1);
    chk("R8 no-op mode", mode_o, 5);
    chk("R8 no-op valid", valid_o, 1);

    // R8 sw reset while busy
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    chk("R8 state", state_o, 0);
    chk("R8 mode", mode_o, 0);
    chk("R8 op", op_o, 0);
    chk("R8 valid", valid_o, 0);
    chk("R9 flush swrst", flush_o, 1);
    settle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule